// File: doc/BRIEF.md
# Byte Split and Fold Adjust Unit

This unit post-processes a 16-bit accumulator, made of a high byte and a low byte, against an 8-bit immediate. It has two operations.

The split operation divides the low byte by the immediate as unsigned integers. The quotient goes to the high byte and the remainder to the low byte. The fold operation multiplies the high byte by the immediate and adds the low byte. It keeps only the low byte of that sum and clears the high byte.

Splitting takes a shift-subtract loop of one bit per cycle. Folding finishes in the cycle after the request. A split by zero does not divide: it reports a divide error and hands the accumulator back unchanged.

After any successful operation, the status flags are those of a logical operation on the new low byte. The surrounding pipeline issues a request by pulsing `start_i` and then waits for `done_o`.

Top module: `bcd_muldiv_adj`

## Requirements
- R1: With `op_i`=0 (split) and a nonzero immediate, the completed result has `acc_o[15:8]` = `acc_i[7:0]` / `imm_i` and `acc_o[7:0]` = `acc_i[7:0]` mod `imm_i`, both unsigned. The input high byte is ignored.
- R2: With `op_i`=0 and `imm_i`=0, `div_err_o` and `done_o` are both high for one cycle, in the cycle after the request. `acc_o` then equals the requested `acc_i`, and `flags_o` keeps its previous value.
- R3: With `op_i`=1 (fold), `acc_o` becomes {8'h00, low byte of (`acc_i[15:8]` * `imm_i` + `acc_i[7:0]`)}. The sum is formed on 16 bits.
- R4: `flags_o` bits are: [0] carry, [1] parity, [2] auxiliary, [3] zero, [4] sign, [5] overflow. After every successful operation, carry, auxiliary and overflow are 0.
- R5: After a successful operation, the zero flag is 1 exactly when `acc_o[7:0]` is 0.
- R6: After a successful operation, the sign flag equals `acc_o[7]`. The parity flag is 1 exactly when `acc_o[7:0]` holds an even number of ones.
- R7: An accepted split with a nonzero immediate raises `busy_o` for exactly 8 cycles, starting in the cycle after the request. `done_o` is high for the single cycle after that, with `busy_o` low.
- R8: A fold, or a split by zero, raises `done_o` in the cycle after the request, and `busy_o` stays low.
- R9: A `start_i` seen while `busy_o` is high is ignored. It changes neither the running result nor the outputs.
- R10: During and right after reset, `busy_o`, `done_o`, `div_err_o`, `acc_o` and `flags_o` are all zero.
- R11: Between completions, `acc_o` and `flags_o` hold their last values. `done_o` and `div_err_o` stay low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request pulse, sampled while not busy |
| op_i | input | 1 | 0 = split (divide), 1 = fold (multiply-add) |
| acc_i | input | 16 | Accumulator operand, high byte [15:8], low byte [7:0] |
| imm_i | input | 8 | Immediate base |
| busy_o | output | 1 | Division loop running |
| done_o | output | 1 | One-cycle completion pulse |
| acc_o | output | 16 | Result accumulator |
| flags_o | output | 6 | Status flags (carry, parity, aux, zero, sign, overflow) |
| div_err_o | output | 1 | Split by zero, pulses with done |

## Verification
The bench builds the unit with its default byte width of 8. This puts the whole divisor range, including 0, 1 and 255, within reach. It also lets the remainder carry bit 7 and the fold sum exceed a byte. The default width also sets the loop to 8 cycles. That gives enough room to fire ignored requests in the middle of a division and to chain requests from the completion cycle. A behavioural model compares every output on every cycle, across a directed set of corner values and a long pseudo-random mix of both operations.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  typedef enum logic {
    OP_SPLIT = 1'b0,
    OP_FOLD  = 1'b1
  } bmd_op_e;

  // bit 0 carry ... bit 5 overflow
  typedef struct packed {
    logic ovf;
    logic sgn;
    logic zro;
    logic aux;
    logic par;
    logic cry;
  } bmd_flags_t;

endpackage

// File: rtl/bmd_flag_gen.sv
module bmd_flag_gen
  import bmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] val_i,
  output bmd_flags_t    flags_o
);

  always_comb begin
    flags_o     = '0;
    flags_o.cry = 1'b0;
    flags_o.aux = 1'b0;
    flags_o.ovf = 1'b0;
    flags_o.par = ~^val_i;
    flags_o.zro = (val_i == '0);
    flags_o.sgn = val_i[DW-1];
  end

endmodule

// File: rtl/bmd_fold.sv
module bmd_fold #(
  parameter int DW = 8
) (
  input  logic [DW-1:0] hi_i,
  input  logic [DW-1:0] lo_i,
  input  logic [DW-1:0] imm_i,
  output logic [DW-1:0] res_o
);

  localparam int WW = 2 * DW;

  logic [WW-1:0] prod;
  logic [WW-1:0] sum;

  always_comb begin
    prod  = WW'(hi_i) * WW'(imm_i);
    sum   = prod + WW'(lo_i);
    res_o = sum[DW-1:0];
  end

endmodule

// File: rtl/bmd_divider.sv
module bmd_divider #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] dividend_i,
  input  logic [DW-1:0] divisor_i,
  output logic          busy_o,
  output logic          fin_o,
  output logic [DW-1:0] quo_nxt_o,
  output logic [DW-1:0] rem_nxt_o
);

  localparam int CW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] rem_q, rem_d;
  logic [DW-1:0] quo_q, quo_d;
  logic [DW-1:0] dvs_q, dvs_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;

  logic [DW:0]   shifted;
  logic [DW-1:0] diff;
  logic          ge;
  logic [DW-1:0] rem_step;
  logic [DW-1:0] quo_step;

  // one restoring step
  always_comb begin
    shifted  = {rem_q, quo_q[DW-1]};
    ge       = (shifted >= {1'b0, dvs_q});
    diff     = shifted[DW-1:0] - dvs_q;
    rem_step = ge ? diff : shifted[DW-1:0];
    quo_step = {quo_q[DW-2:0], ge};
  end

  always_comb begin
    rem_d  = rem_q;
    quo_d  = quo_q;
    dvs_d  = dvs_q;
    cnt_d  = cnt_q;
    busy_d = busy_q;
    if (load_i) begin
      rem_d  = '0;
      quo_d  = dividend_i;
      dvs_d  = divisor_i;
      cnt_d  = '0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      rem_d = rem_step;
      quo_d = quo_step;
      cnt_d = cnt_q + 1'b1;
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      if (load_i || busy_q) begin
        rem_q <= rem_d;
        quo_q <= quo_d;
        cnt_q <= cnt_d;
      end
      if (load_i) begin
        dvs_q <= dvs_d;
      end
      busy_q <= busy_d;
    end
  end

  assign busy_o    = busy_q;
  assign fin_o     = busy_q && (cnt_q == LAST);
  assign quo_nxt_o = quo_step;
  assign rem_nxt_o = rem_step;

  // R1
  rem_below_dvs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (rem_q < dvs_q));

  // R2
  dvs_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (dvs_q != '0));

endmodule

// File: rtl/bcd_muldiv_adj.sv
module bcd_muldiv_adj
  import bmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic            op_i,
  input  logic [2*DW-1:0] acc_i,
  input  logic [DW-1:0]   imm_i,
  output logic            busy_o,
  output logic            done_o,
  output logic [2*DW-1:0] acc_o,
  output logic [5:0]      flags_o,
  output logic            div_err_o
);

  localparam int AW = 2 * DW;
  localparam int NSRC = 2;

  // reset synchronizer
  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  bmd_op_e       op;
  logic          div_busy, div_fin;
  logic [DW-1:0] div_quo, div_rem;
  logic [DW-1:0] fold_res;
  logic          accept, acc_fold, acc_zero, load_div;

  assign op       = bmd_op_e'(op_i);
  assign accept   = start_i && !div_busy;
  assign acc_fold = accept && (op == OP_FOLD);
  assign acc_zero = accept && (op == OP_SPLIT) && (imm_i == '0);
  assign load_div = accept && (op == OP_SPLIT) && (imm_i != '0);

  bmd_divider #(.DW(DW)) u_div (
    .clk        (clk),
    .rst_n      (rst_sync_q),
    .load_i     (load_div),
    .dividend_i (acc_i[DW-1:0]),
    .divisor_i  (imm_i),
    .busy_o     (div_busy),
    .fin_o      (div_fin),
    .quo_nxt_o  (div_quo),
    .rem_nxt_o  (div_rem)
  );

  bmd_fold #(.DW(DW)) u_fold (
    .hi_i  (acc_i[AW-1:DW]),
    .lo_i  (acc_i[DW-1:0]),
    .imm_i (imm_i),
    .res_o (fold_res)
  );

  // flag sources: 0 = divider remainder, 1 = fold result
  logic [DW-1:0] flag_src [NSRC];
  bmd_flags_t    flag_val [NSRC];
  assign flag_src[0] = div_rem;
  assign flag_src[1] = fold_res;

  for (genvar g = 0; g < NSRC; g++) begin : g_flag
    bmd_flag_gen #(.DW(DW)) u_fg (
      .val_i   (flag_src[g]),
      .flags_o (flag_val[g])
    );
  end

  logic [AW-1:0] acc_q, acc_d;
  bmd_flags_t    flg_q, flg_d;
  logic          done_q, done_d;
  logic          err_q, err_d;
  logic          acc_en, flg_en;

  always_comb begin
    acc_d  = acc_q;
    flg_d  = flg_q;
    done_d = 1'b0;
    err_d  = 1'b0;
    acc_en = 1'b0;
    flg_en = 1'b0;
    if (div_fin) begin
      acc_d  = {div_quo, div_rem};
      flg_d  = flag_val[0];
      done_d = 1'b1;
      acc_en = 1'b1;
      flg_en = 1'b1;
    end else if (acc_fold) begin
      acc_d  = {{DW{1'b0}}, fold_res};
      flg_d  = flag_val[1];
      done_d = 1'b1;
      acc_en = 1'b1;
      flg_en = 1'b1;
    end else if (acc_zero) begin
      acc_d  = acc_i;
      done_d = 1'b1;
      err_d  = 1'b1;
      acc_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      acc_q  <= '0;
      flg_q  <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (acc_en) begin
        acc_q <= acc_d;
      end
      if (flg_en) begin
        flg_q <= flg_d;
      end
      done_q <= done_d;
      err_q  <= err_d;
    end
  end

  assign busy_o    = div_busy;
  assign done_o    = done_q;
  assign acc_o     = acc_q;
  assign flags_o   = flg_q;
  assign div_err_o = err_q;

  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    busy_o |-> !done_o);

  // R7
  loop_end_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    $fell(busy_o) |-> done_o);

  // R2
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    div_err_o |-> done_o);

  // R2
  err_acc_keep_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    div_err_o |-> (acc_o == $past(acc_i)));

  // R4
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done_o && !div_err_o) |-> (!flags_o[0] && !flags_o[2] && !flags_o[5]));

  // R6
  sign_bit_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done_o && !div_err_o) |-> (flags_o[4] == acc_o[DW-1]));

  // R3
  fold_hi_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (done_o && !div_err_o && !$past(busy_o)) |-> (acc_o[AW-1:DW] == '0));

endmodule

// File: tb/tb_bcd_muldiv_adj.sv
module tb_bcd_muldiv_adj;

  localparam int DW = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_i = 1'b0;
  logic        op_i = 1'b0;
  logic [15:0] acc_i = '0;
  logic [7:0]  imm_i = '0;
  logic        busy_o, done_o, div_err_o;
  logic [15:0] acc_o;
  logic [5:0]  flags_o;

  always #2 clk = ~clk;

  bcd_muldiv_adj #(.DW(DW)) dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .op_i      (op_i),
    .acc_i     (acc_i),
    .imm_i     (imm_i),
    .busy_o    (busy_o),
    .done_o    (done_o),
    .acc_o     (acc_o),
    .flags_o   (flags_o),
    .div_err_o (div_err_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit chk_on = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // flag vector from the requirement bit layout (R4 R5 R6)
  function automatic logic [5:0] exp_flags(input logic [7:0] v);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += v[i];
    return {1'b0, v[7], (v == 8'h00), 1'b0, ((ones % 2) == 0), 1'b0};
  endfunction

  // behavioural reference
  int          m_cnt;
  logic [15:0] m_acc, m_pend;
  logic [5:0]  m_flags;
  bit          m_done, m_err, m_busy;
  string       m_tag;
  bit          was_busy;
  int          tmp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_acc = '0; m_pend = '0; m_flags = '0;
      m_done = 0; m_err = 0; m_tag = "R10";
    end else begin
      was_busy = (m_cnt != 0);
      m_done = 0;
      m_err  = 0;
      if (m_cnt > 0) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_acc = m_pend;
          m_flags = exp_flags(m_pend[7:0]);
          m_done = 1;
          m_tag = "R1";
        end
      end
      if (start_i && !was_busy) begin
        if (op_i) begin
          tmp = int'(acc_i[15:8]) * int'(imm_i) + int'(acc_i[7:0]);
          m_acc = {8'h00, tmp[7:0]};
          m_flags = exp_flags(tmp[7:0]);
          m_done = 1;
          m_tag = "R3";
        end else if (imm_i == 0) begin
          m_acc = acc_i;
          m_done = 1;
          m_err = 1;
          m_tag = "R2";
        end else begin
          m_pend = {8'(acc_i[7:0] / imm_i), 8'(acc_i[7:0] % imm_i)};
          m_cnt = DW;
        end
      end
    end
    m_busy = (m_cnt != 0);
  end

  // compare on every cycle, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !finished) begin
      check(busy_o === m_busy, "R7/R8/R9", "busy", 16'(busy_o), 16'(m_busy));
      check(done_o === m_done, "R7/R8/R11", "done", 16'(done_o), 16'(m_done));
      check(div_err_o === m_err, "R2/R11", "div_err", 16'(div_err_o), 16'(m_err));
      check(acc_o === m_acc, m_done ? m_tag : "R11", "acc", acc_o, m_acc);
      check(flags_o === m_flags, "R4/R5/R6", "flags", 16'(flags_o), 16'(m_flags));
    end
  end

  task automatic issue(input bit op, input logic [15:0] a, input logic [7:0] b);
    @(negedge clk);
    start_i = 1'b1; op_i = op; acc_i = a; imm_i = b;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(3);
    // R10 explicit reset state
    check({busy_o, done_o, div_err_o} === 3'b000, "R10", "ctrl after reset",
          16'({busy_o, done_o, div_err_o}), 16'h0);
    check(acc_o === 16'h0 && flags_o === 6'h0, "R10", "data after reset", acc_o, 16'h0);
    chk_on = 1;

    // R1 split corners
    issue(0, 16'h12_FF, 8'd10);  idle(10);
    issue(0, 16'hAB_C8, 8'd250); idle(10);   // remainder with bit 7 set
    issue(0, 16'h00_FF, 8'd1);   idle(10);
    issue(0, 16'h00_FF, 8'd255); idle(10);   // zero remainder, R5
    issue(0, 16'h00_00, 8'd7);   idle(10);
    issue(0, 16'h77_05, 8'd9);   idle(10);
    // R2 split by zero; flags must hold
    issue(0, 16'hBEEF, 8'd0);    idle(3);
    // R3 fold, sum wraps past a byte
    issue(1, 16'h09_09, 8'd10);  idle(2);
    issue(1, 16'hFF_FF, 8'd255); idle(2);
    issue(1, 16'h00_00, 8'd0);   idle(2);
    issue(1, 16'h0C_80, 8'd16);  idle(2);
    // R9 requests during a running division are ignored
    issue(0, 16'h00_64, 8'd7);
    idle(2);
    issue(1, 16'h11_11, 8'd3);
    issue(0, 16'h00_05, 8'd0);
    idle(8);
    // back-to-back: start held through completion cycles
    @(negedge clk);
    start_i = 1'b1; op_i = 1'b1; acc_i = 16'h0203; imm_i = 8'd10;
    @(negedge clk); acc_i = 16'h0401;
    @(negedge clk); op_i = 1'b0; acc_i = 16'h00F0; imm_i = 8'd16;
    @(negedge clk); start_i = 1'b0;
    idle(12);
    // mixed pseudo-random traffic
    for (int k = 0; k < 600; k++) begin
      logic [31:0] r;
      r = $urandom;
      issue(r[0], r[31:16], (r[3:1] == 3'd0) ? 8'd0 : r[15:8]);
      idle(int'(r[6:4]));
    end
    idle(12);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule